// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

A synthesizable behavioural model of an asynchronous 16-bit static memory with two independently gated byte lanes. The block takes the memory's classic active-low control pins: chip select, write enable, output enable, and one enable per byte. It decodes each combination into one of four outcomes for every lane: standby, write, read or output-disabled.

The bidirectional data pins are split into a data input bus, a data output bus and a two-bit drive-enable vector, one bit per byte lane. A wrapper can then build a tristate pad from them, or use them directly inside an FPGA or a testbench.

Reads are combinational from the current address. A write commits on the rising edge of the model clock in any cycle where chip select, write enable and at least one byte enable are all active. Storage is not reset, so a location must be written before it is read. The depth is set by the address-width parameter. The full-size configuration, `ADDR_W = 16`, gives 65,536 words; the default is smaller to keep elaboration light.

Top module: `sram_bytelane_model`

## Requirements
- R1: Storage holds 2**ADDR_W words of 16 bits (65,536 words when ADDR_W is 16). A word written at one address reads back unchanged and is not disturbed by writes to other addresses, including address 0 and the highest address.
- R2: While cs_n is 1 the drive-enable vector is 00 whatever the other controls are, and no storage changes.
- R3: A lane is written at a rising clock edge only while cs_n is 0, we_n is 0 and that lane's enable is 0. lb_n gates data bits 7:0 and ub_n gates bits 15:8.
- R4: During a write cycle (cs_n 0, we_n 0) the drive-enable vector is 00 whatever oe_n is. A lane whose enable is 1 keeps its stored byte.
- R5: With cs_n 0, we_n 1 and oe_n 0, drive_en bit 0 is the inverse of lb_n and drive_en bit 1 is the inverse of ub_n. Each driven lane shows the stored byte of the current address combinationally.
- R6: With cs_n 0 and we_n 1, drive_en is 00 when oe_n is 1 or when both lb_n and ub_n are 1.
- R7: The data_out bits of a lane whose drive-enable bit is 0 read as zero.
- R8: A write cycle with both byte enables at 1 changes no stored data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model sampling clock; writes commit on its rising edge |
| rst | input | 1 | Synchronous active-high reset, qualifies the checks; storage is not cleared |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper byte (bits 15:8) enable, active low |
| lb_n | input | 1 | Lower byte (bits 7:0) enable, active low |
| addr | input | ADDR_W | Word address |
| data_in | input | 16 | Write data from the bus |
| data_out | output | 16 | Read data, zero in undriven lanes |
| drive_en | output | 2 | Per-lane output drive: bit 0 lower, bit 1 upper |

## Verification
On every clock, the assertions check how the controls map onto the drive-enable vector: deselect, write, read and output-disabled. They also check that a lane write happens only under its full set of conditions, and that undriven lanes read as zero.

Only the bench scenarios can show what storage holds. These cover correct data after a write, a byte kept when its lane is masked, no change after a deselected or lane-less write, and no aliasing between the lowest, middle and highest addresses. The assertions cannot see these without a copy of the array.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_WRITE   = 2'd1,
        MODE_READ    = 2'd2,
        MODE_QUIET   = 2'd3
    } sram_mode_e;

    typedef struct packed {
        logic             cs_n;
        logic             we_n;
        logic             oe_n;
        logic [LANES-1:0] lane_n;
    } sram_ctrl_t;

    function automatic sram_mode_e classify(input sram_ctrl_t c);
        if (c.cs_n)
            return MODE_STANDBY;
        else if (!c.we_n)
            return MODE_WRITE;
        else if (!c.oe_n && (c.lane_n != '1))
            return MODE_READ;
        else
            return MODE_QUIET;
    endfunction

endpackage

// File: rtl/sram_ctrl_decode.sv
module sram_ctrl_decode
    import sram_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  sram_ctrl_t       ctrl,
    output sram_mode_e       mode,
    output logic [LANES-1:0] lane_wr,
    output logic [LANES-1:0] lane_drv
);

    assign mode = classify(ctrl);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            lane_wr[g]  = (mode == MODE_WRITE) && !ctrl.lane_n[g];
            lane_drv[g] = (mode == MODE_READ)  && !ctrl.lane_n[g];
        end

        assert_lane_write_cond_R3: assert property (@(posedge clk) disable iff (rst)
            lane_wr[g] |-> (!ctrl.cs_n && !ctrl.we_n && !ctrl.lane_n[g]));
    end

    assert_no_drive_and_write_R4: assert property (@(posedge clk) disable iff (rst)
        (lane_wr != '0) |-> (lane_drv == '0));

endmodule

// File: rtl/sram_lane.sv
module sram_lane
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              drv_en,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] rd_byte;

    always_ff @(posedge clk) begin
        if (wr_en)
            store[addr] <= din;
    end

    assign rd_byte = store[addr];
    assign dout    = drv_en ? rd_byte : '0;

    assert_undriven_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !drv_en |-> (dout == '0));

endmodule

// File: rtl/sram_bytelane_model.sv
module sram_bytelane_model
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       data_in,
    output logic [15:0]       data_out,
    output logic [1:0]        drive_en
);

    sram_ctrl_t       ctrl;
    sram_mode_e       mode;
    logic [LANES-1:0] lane_wr;
    logic [LANES-1:0] lane_drv;

    assign ctrl = '{cs_n: cs_n, we_n: we_n, oe_n: oe_n, lane_n: {ub_n, lb_n}};

    sram_ctrl_decode u_decode (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .mode     (mode),
        .lane_wr  (lane_wr),
        .lane_drv (lane_drv)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane #(.ADDR_W(ADDR_W)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .addr   (addr),
            .wr_en  (lane_wr[g]),
            .drv_en (lane_drv[g]),
            .din    (data_in[g*LANE_W +: LANE_W]),
            .dout   (data_out[g*LANE_W +: LANE_W])
        );
    end

    assign drive_en = lane_drv;

    assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (drive_en == 2'b00));

    assert_write_no_drive_R4: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !we_n) |-> (drive_en == 2'b00));

    assert_read_lanes_R5: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && we_n && !oe_n) |-> (drive_en == ~{ub_n, lb_n}));

    assert_output_off_R6: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && we_n && (oe_n || (ub_n && lb_n))) |-> (drive_en == 2'b00));

    assert_mode_standby_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STANDBY) |-> (lane_wr == '0));

endmodule

// File: tb/sram_bytelane_model_bench.sv
module sram_bytelane_model_bench;

    localparam int ADDR_W = 10;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       data_in = '0;
    logic [15:0]       data_out;
    logic [1:0]        drive_en;

    logic [15:0] shadow [DEPTH];
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sram_bytelane_model #(.ADDR_W(ADDR_W)) u_sram_bytelane_model (
        .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .data_in(data_in),
        .data_out(data_out), .drive_en(drive_en)
    );

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual drive=%b data=%h expected drive=%b data=%h",
                     req, act[17:16], act[15:0], exp[17:16], exp[15:0]);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; ub_n = 1'b1; lb_n = 1'b1;
    endtask

    // write cycle; lanes_n = {ub_n, lb_n}; checks no drive during the write (R4)
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                      input logic [1:0] lanes_n, input logic oe, input logic cs);
        @(negedge clk);
        addr = a; data_in = d; cs_n = cs; we_n = 1'b0; oe_n = oe;
        {ub_n, lb_n} = lanes_n;
        #1 chk("R4 no drive in write", {drive_en, data_out}, 18'h0);
        if (!cs) begin
            if (!lanes_n[0]) shadow[a][7:0]  = d[7:0];
            if (!lanes_n[1]) shadow[a][15:8] = d[15:8];
        end
        idle();
    endtask

    task automatic rd(input string req, input logic [ADDR_W-1:0] a,
                      input logic [1:0] lanes_n, input logic oe);
        logic [1:0]  exp_drv;
        logic [15:0] exp_dat;
        @(negedge clk);
        addr = a; data_in = 16'hDEAD; cs_n = 1'b0; we_n = 1'b1; oe_n = oe;
        {ub_n, lb_n} = lanes_n;
        exp_drv = oe ? 2'b00 : ~lanes_n;
        exp_dat = {exp_drv[1] ? shadow[a][15:8] : 8'h00, exp_drv[0] ? shadow[a][7:0] : 8'h00};
        #1 chk(req, {drive_en, data_out}, {exp_drv, exp_dat});
        idle();
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk("R2 deselected after reset", {drive_en, data_out}, 18'h0);
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0;
        #1 chk("R2 R7 deselect with read controls", {drive_en, data_out}, 18'h0);
        idle();
    endtask

    task automatic t_word_rw();
        wr(10'd0,   16'h1234, 2'b00, 1'b1, 1'b0);
        wr(10'd1023, 16'hABCD, 2'b00, 1'b1, 1'b0);
        wr(10'd512, 16'h5AA5, 2'b00, 1'b1, 1'b0);
        rd("R1 R5 word at address 0", 10'd0, 2'b00, 1'b0);
        rd("R1 R5 word at top address", 10'd1023, 2'b00, 1'b0);
        rd("R1 R5 word at mid address", 10'd512, 2'b00, 1'b0);
    endtask

    task automatic t_lane_writes();
        wr(10'd7, 16'hFFFF, 2'b00, 1'b1, 1'b0);
        wr(10'd7, 16'h2211, 2'b10, 1'b1, 1'b0);   // lower only
        rd("R3 R4 lower-only write keeps upper", 10'd7, 2'b00, 1'b0);
        wr(10'd7, 16'h4433, 2'b01, 1'b0, 1'b0);   // upper only, oe low
        rd("R3 R4 upper-only write keeps lower", 10'd7, 2'b00, 1'b0);
    endtask

    task automatic t_blocked_writes();
        wr(10'd9, 16'h0F0F, 2'b00, 1'b1, 1'b0);
        wr(10'd9, 16'hEEEE, 2'b11, 1'b0, 1'b0);   // no lane
        rd("R8 lane-less write leaves data", 10'd9, 2'b00, 1'b0);
        wr(10'd9, 16'hCCCC, 2'b00, 1'b1, 1'b1);   // deselected
        rd("R2 deselected write leaves data", 10'd9, 2'b00, 1'b0);
    endtask

    task automatic t_partial_reads();
        rd("R5 R7 lower lane read", 10'd0, 2'b10, 1'b0);
        rd("R5 R7 upper lane read", 10'd1023, 2'b01, 1'b0);
        rd("R6 oe high no drive", 10'd512, 2'b00, 1'b1);
        rd("R6 both lanes off no drive", 10'd512, 2'b11, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_word_rw();
        t_lane_writes();
        t_blocked_writes();
        t_partial_reads();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule